// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a behavioural, synthesizable model of a single-port synchronous SRAM. It has a small array whose size is set by parameters. Every control, address and data input is sampled on the rising clock edge. A new access begins when either of two active-low strobes is asserted. The processor strobe always begins a read. The controller strobe begins a read or a write, depending on the write controls.

After an access begins, the advance input steps a two-bit beat counter. That counter forms the low two address bits of the next beats, so a burst covers four words. The order pin picks the sequence: a linear order that wraps inside the aligned group of four, or an interleaved order. Writes can be enabled per byte lane, or for all lanes through the global write. Read data pass through an array read register and then an output register. An asynchronous output enable gates the valid flag on the output.

Top module: `sbsram_top`

## Requirements
- R1: Synchronous reset (rst high) clears the output pipeline (q_valid_o=0, q_o=0), deselects the device and zeroes every array word.
- R2: The address and the chip-select state are captured only on an edge where pstb_n or cstb_n is low. addr_i is ignored on every other edge.
- R3: On an edge with no strobe and adv_n low, the beat counter increments (mod 4). On an edge with no strobe and adv_n high, the counter holds and the same word is accessed again.
- R4: With order_i=0 (linear), beat k accesses low bits (start+k) mod 4. The upper address bits stay fixed, and the fifth beat wraps back to the start word.
- R5: With order_i=1 (interleaved), beat k accesses low bits start XOR k.
- R6: Lane l is data bits [9l+8:9l]. It is written when lane_we_n[l]=0 and lane_qual_n=0. With lane_qual_n=1 no lane is written, and the cycle becomes a read.
- R7: all_we_n=0 writes all lanes, whatever lane_we_n and lane_qual_n show.
- R8: An edge with pstb_n low and the chip selected is a read, even when write controls are active. The array is unchanged.
- R9: A read at edge N shows on q_o, with q_valid_o=1, after edge N+1. A write cycle gives q_valid_o=0 in the corresponding output slot.
- R10: oe_n=1 forces q_valid_o low at once, without waiting for a clock edge.
- R11: The chip is selected only when sel0_n=0, sel1=1 and sel2_n=0. A strobe that samples any other combination deselects it. Deselected cycles read and write nothing, and q_valid_o is low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, captured on strobe edges |
| wdata_i | input | LANES*LANE_W | Write data |
| pstb_n | input | 1 | Processor strobe, active low, forces read |
| cstb_n | input | 1 | Controller strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| lane_qual_n | input | 1 | Qualifier for the lane enables, active low |
| all_we_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| q_o | output | LANES*LANE_W | Registered read data |
| q_valid_o | output | 1 | Read data valid and driven |

## Verification
The bench builds the block with its defaults: 6 address bits (64 words) and four 9-bit lanes. At this size the bench can write every word of the array with an arithmetic pattern. It then runs a burst of every start offset in both orders, including the wrap on the fifth beat. The small lane count lets the bench check partial lane masks, qualifier suppression and the global override word by word. A bench-side model of strobe, advance and select rules predicts each output slot.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic       on;
        logic [1:0] cnt;
    } burst_st_t;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input burst_order_e ord);
        logic [1:0] r;
        if (ord == ORD_INTERLEAVE) r = start ^ cnt;
        else                       r = start + cnt;
        return r;
    endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              lane_qual_n,
    input  logic              all_we_n,
    input  logic              order_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [LANES-1:0]  acc_wmask_o,
    output acc_kind_e         acc_kind_o
);

    logic [ADDR_W-1:0] base_q, base_n;
    burst_st_t         st_q, st_n;
    logic              strobe;
    logic              chip_on;
    logic [LANES-1:0]  mask;

    assign strobe  = !pstb_n || !cstb_n;
    assign chip_on = !sel0_n && sel1 && !sel2_n;

    always_comb begin
        st_n   = st_q;
        base_n = base_q;
        if (strobe) begin
            base_n = addr_i;
            st_n.on  = chip_on;
            st_n.cnt = 2'd0;
        end else if (!adv_n) begin
            st_n.cnt = st_q.cnt + 2'd1;
        end
    end

    always_comb begin
        mask = '0;
        if (st_n.on && pstb_n) begin
            if (!all_we_n)         mask = '1;
            else if (!lane_qual_n) mask = ~lane_we_n;
        end
    end

    always_comb begin
        acc_addr_o  = {base_n[ADDR_W-1:2],
                       burst_lo(base_n[1:0], st_n.cnt, burst_order_e'(order_i))};
        acc_wmask_o = mask;
        if (!st_n.on)      acc_kind_o = ACC_NONE;
        else if (|mask)    acc_kind_o = ACC_WRITE;
        else               acc_kind_o = ACC_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            st_q   <= '{on: 1'b0, cnt: 2'd0};
        end else begin
            base_q <= base_n;
            st_q   <= st_n;
        end
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       acc_addr_i,
    input  logic [LANES-1:0]        acc_wmask_i,
    input  acc_kind_e               acc_kind_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvld_o
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata_o <= '0;
            rvld_o  <= 1'b0;
        end else begin
            if (acc_kind_i == ACC_WRITE) begin
                for (int l = 0; l < LANES; l++) begin
                    if (acc_wmask_i[l])
                        mem[acc_addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
                end
            end
            if (acc_kind_i == ACC_READ) rdata_o <= mem[acc_addr_i];
            rvld_o <= (acc_kind_i == ACC_READ);
        end
    end

endmodule

// File: rtl/sbsram_outpipe.sv
module sbsram_outpipe #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              rvld_i,
    input  logic              oe_n,
    output logic [DATA_W-1:0] q_o,
    output logic              q_valid_o
);

    logic [DATA_W-1:0] q_q;
    logic              v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
            v_q <= 1'b0;
        end else begin
            q_q <= rdata_i;
            v_q <= rvld_i;
        end
    end

    assign q_o       = q_q;
    assign q_valid_o = v_q && !oe_n;

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    adv_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    lane_qual_n,
    input  logic                    all_we_n,
    input  logic                    oe_n,
    input  logic                    order_i,
    output logic [LANES*LANE_W-1:0] q_o,
    output logic                    q_valid_o
);

    localparam int DATA_W = LANES * LANE_W;

    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_wmask;
    acc_kind_e         acc_kind;
    logic [DATA_W-1:0] rdata;
    logic              rvld;

    sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .lane_we_n(lane_we_n), .lane_qual_n(lane_qual_n),
        .all_we_n(all_we_n), .order_i(order_i),
        .acc_addr_o(acc_addr), .acc_wmask_o(acc_wmask), .acc_kind_o(acc_kind)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .rst(rst),
        .acc_addr_i(acc_addr), .acc_wmask_i(acc_wmask), .acc_kind_i(acc_kind),
        .wdata_i(wdata_i), .rdata_o(rdata), .rvld_o(rvld)
    );

    sbsram_outpipe #(.DATA_W(DATA_W)) out_i (
        .clk(clk), .rst(rst), .rdata_i(rdata), .rvld_i(rvld),
        .oe_n(oe_n), .q_o(q_o), .q_valid_o(q_valid_o)
    );

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk (
    input logic clk,
    input logic rst,
    input logic pstb_n,
    input logic cstb_n,
    input logic sel0_n,
    input logic sel1,
    input logic sel2_n,
    input logic all_we_n,
    input logic oe_n,
    input logic q_valid_o
);

    logic on;
    assign on = !sel0_n && sel1 && !sel2_n;

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((!pstb_n || !cstb_n) && !on) |-> ##2 !q_valid_o); // R11

    AST_PSTB_READS: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n && on) |-> ##2 (q_valid_o || oe_n)); // R8

    AST_GWRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && !cstb_n && on && !all_we_n) |-> ##2 !q_valid_o); // R9

    always_comb begin
        if (!rst && oe_n) begin
            AST_OE_GATE: assert (!q_valid_o); // R10
        end
    end

endmodule

bind sbsram_top sbsram_chk chk_i (
    .clk(clk), .rst(rst), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .all_we_n(all_we_n), .oe_n(oe_n), .q_valid_o(q_valid_o)
);

// File: tb/sbsram_top_tb_top.sv
`timescale 1ns/1ps
module sbsram_top_tb_top;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int DW = 36;
    localparam logic [2:0] SEL_ON = 3'b010; // {sel2_n, sel1, sel0_n}

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] wdata_i;
    logic          pstb_n, cstb_n, adv_n, sel0_n, sel1, sel2_n;
    logic [NL-1:0] lane_we_n;
    logic          lane_qual_n, all_we_n, oe_n, order_i;
    logic [DW-1:0] q_o;
    logic          q_valid_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [DW-1:0] model [64];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt  = '0;
    logic          m_on   = 1'b0;
    logic          p_v    = 1'b0;
    logic [DW-1:0] p_d    = '0;
    string         p_tag  = "R9";

    always #4 clk = ~clk;

    sbsram_top dut_i (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .lane_we_n(lane_we_n), .lane_qual_n(lane_qual_n),
        .all_we_n(all_we_n), .oe_n(oe_n), .order_i(order_i),
        .q_o(q_o), .q_valid_o(q_valid_o)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 40503 + 17) ^ {4'hA, 32'h0};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; checks the output slot of the previous access.
    task automatic step(input logic ps, input logic cs, input logic adv,
                        input logic [AW-1:0] a, input logic [NL-1:0] lwe,
                        input logic lq, input logic aw, input logic [2:0] sel,
                        input logic ord, input logic [DW-1:0] d, input string tag);
        logic [1:0]    lo;
        logic [AW-1:0] ea;
        logic [NL-1:0] mask;
        logic          ev;
        logic [DW-1:0] ed;
        pstb_n = ps; cstb_n = cs; adv_n = adv; addr_i = a;
        lane_we_n = lwe; lane_qual_n = lq; all_we_n = aw;
        {sel2_n, sel1, sel0_n} = sel; order_i = ord; wdata_i = d;
        if (!ps || !cs) begin
            m_base = a; m_cnt = 2'd0; m_on = (sel == SEL_ON);
        end else if (!adv) begin
            m_cnt = m_cnt + 2'd1;
        end
        lo   = ord ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
        ea   = {m_base[AW-1:2], lo};
        mask = '0;
        if (m_on && ps) begin
            if (!aw)      mask = '1;
            else if (!lq) mask = ~lwe;
        end
        ev = m_on && (mask == '0);
        ed = model[ea];
        for (int l = 0; l < NL; l++)
            if (mask[l]) model[ea][l*9 +: 9] = d[l*9 +: 9];
        @(posedge clk);
        @(negedge clk);
        chk(q_valid_o == p_v, {p_tag, " valid"}, DW'(q_valid_o), DW'(p_v));
        if (p_v) chk(q_o == p_d, {p_tag, " data"}, q_o, p_d);
        p_v = ev; p_d = ed; p_tag = tag;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic ord, input string tag);
        step(1'b0, 1'b1, 1'b1, a, '1, 1'b1, 1'b1, SEL_ON, ord, '0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] lwe, input logic lq,
                      input logic aw, input logic [DW-1:0] d, input string tag);
        step(1'b1, 1'b0, 1'b1, a, lwe, lq, aw, SEL_ON, 1'b0, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        rst = 1'b1; oe_n = 1'b0;
        pstb_n = 1; cstb_n = 1; adv_n = 1; addr_i = '0; wdata_i = '0;
        {sel2_n, sel1, sel0_n} = SEL_ON; lane_we_n = '1; lane_qual_n = 1;
        all_we_n = 1; order_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(q_valid_o == 1'b0, "R1 reset valid", DW'(q_valid_o), '0);
        chk(q_o == '0, "R1 reset data", q_o, '0);

        // idle after reset: deselected, nothing comes out (R1, R11)
        step(1, 1, 1, 6'd7, '1, 1, 1, SEL_ON, 0, '0, "R11 idle");
        rd(6'd5, 0, "R1 zero array");
        rd(6'd63, 0, "R1 zero array");

        // fill every word with global writes (R7, R9 no valid on write)
        for (int a = 0; a < 64; a++) wr(6'(a), '1, 1, 0, pat(a), "R7 fill");

        // all start offsets, both orders, five beats to show wrap (R4, R5, R2)
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] b;
                b = {2'(o + 1), 2'(s), 2'(s)};
                rd(b, 1'(o), "R2 burst start");
                for (int k = 0; k < 5; k++)
                    step(1, 1, 0, ~b, '1, 1, 1, SEL_ON, 1'(o), '0,
                         o ? "R5 interleave beat" : "R4 linear beat");
            end
        end

        // hold: no strobe, no advance, different addr_i presented (R3, R2)
        rd(6'd9, 0, "R3 hold start");
        step(1, 1, 1, 6'd50, '1, 1, 1, SEL_ON, 0, '0, "R3 hold repeat");
        step(1, 1, 1, 6'd51, '1, 1, 1, SEL_ON, 0, '0, "R3 hold repeat");

        // lane writes (R6)
        wr(6'd20, 4'b1010, 0, 1, {4{9'h1FF}}, "R6 lanes 0,2");
        rd(6'd20, 0, "R6 lane readback");
        wr(6'd21, 4'b0000, 1, 1, {4{9'h155}}, "R6 qualifier off reads");
        rd(6'd21, 0, "R6 unchanged");
        wr(6'd24, 4'b0111, 0, 1, {4{9'h0AA}}, "R6 lane 3");
        rd(6'd24, 0, "R6 lane readback");

        // global write beats lane controls (R7)
        wr(6'd22, 4'b1111, 1, 0, 36'h123456789, "R7 global");
        rd(6'd22, 0, "R7 readback");

        // processor strobe ignores write controls (R8)
        step(0, 0, 1, 6'd23, 4'b0000, 0, 0, SEL_ON, 0, 36'hFEDCBA987, "R8 pstb read");
        rd(6'd23, 0, "R8 unchanged");

        // burst write then burst read, linear (R3, R6, R9)
        wr(6'd30, '1, 1, 0, 36'h0A0A0A0A0, "R9 burst wr");
        step(1, 1, 0, 6'd0, 4'b1100, 0, 1, SEL_ON, 0, 36'h111111111, "R6 burst lane wr");
        step(1, 1, 0, 6'd0, '1, 1, 0, SEL_ON, 0, 36'h222222222, "R7 burst wr");
        rd(6'd30, 0, "R9 burst rd");
        step(1, 1, 0, 6'd1, '1, 1, 1, SEL_ON, 0, '0, "R4 burst rd");
        step(1, 1, 0, 6'd1, '1, 1, 1, SEL_ON, 0, '0, "R4 burst rd");

        // each chip enable deselects; writes while deselected are dropped (R11)
        for (int c = 0; c < 3; c++) begin
            logic [2:0] bad;
            bad = SEL_ON ^ (3'b001 << c);
            step(0, 1, 1, 6'd40, '1, 1, 1, bad, 0, '0, "R11 deselect");
            step(1, 1, 0, 6'd40, '1, 1, 0, SEL_ON, 0, 36'h0DEAD0000, "R11 adv ignored");
            step(1, 0, 1, 6'd41, '1, 1, 0, bad, 0, 36'h0BEEF0000, "R11 write dropped");
            step(1, 1, 1, 6'd41, '1, 1, 1, SEL_ON, 0, '0, "R11 quiet");
        end
        rd(6'd40, 0, "R11 word 40 intact");
        rd(6'd41, 0, "R11 word 41 intact");

        // asynchronous output enable (R10)
        rd(6'd3, 0, "R10 read");
        step(1, 1, 1, 6'd3, '1, 1, 1, SEL_ON, 0, '0, "R10 hold");
        oe_n = 1'b1;
        #1;
        chk(q_valid_o == 1'b0, "R10 oe off", DW'(q_valid_o), '0);
        oe_n = 1'b0;
        #1;
        chk(q_valid_o == 1'b1, "R10 oe on", DW'(q_valid_o), DW'(1));
        step(1, 1, 1, 6'd3, '1, 1, 1, SEL_ON, 0, '0, "R9 tail");
        step(0, 1, 1, 6'd3, '1, 1, 1, 3'b000, 0, '0, "R11 final");
        step(1, 1, 1, 6'd3, '1, 1, 1, SEL_ON, 0, '0, "R11 final");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule